// File: doc/BRIEF.md
# Strap-Addressed I2C Target Interface

This block is the target (slave) side of a two-wire serial control bus. A fast internal clock oversamples the bus clock and data lines and resynchronises them. The block detects the bus start and stop conditions and shifts in the first byte of each transfer, most significant bit first. It compares the upper seven bits of that byte with a fixed address whose lowest bit comes from a strap pin. It never drives the bus clock. It drives the data line only low, through an open-drain enable.

When the address matches, the block acknowledges. In a write, the next byte sets an internal register index, and every later byte is handed to a register port as a one-cycle write strobe, after which the index increments. In a read, the block fetches the byte at the current index through the same port and shifts it out. It keeps fetching and incrementing for as long as the bus controller acknowledges. A not-acknowledge ends the read. The index is kept across transfers. The register storage itself lies outside the block.

The internal clock must run at least ten times faster than the bus clock. Bus rates up to 400 kbit/s are expected.

Top module: `pinaddr_i2c_slave`

## Requirements
- R1: While reset is asserted and right after it, `sdaOe` is 0 and neither `regWrEn` nor `regRdEn` is asserted.
- R2: A falling edge of the synchronised SDA while the synchronised SCL is high is a START. It restarts address reception from any state, including during a transfer (repeated START). A rising edge of the synchronised SDA while SCL is high is a STOP. It returns the block to idle from any state, including in the middle of a byte.
- R3: The first byte after START is sampled on SCL rising edges, MSB first, with bit 0 as R/W (1 = read). When `addrSel` = 0, the byte 0x38 (write) or 0x39 (read) is acknowledged. When `addrSel` = 1, the byte 0x3A or 0x3B is acknowledged. To acknowledge, the block asserts `sdaOe` for the whole ninth clock.
- R4: When the address does not match, the block never asserts `sdaOe` and produces no register strobes until the next START.
- R5: In a write, the byte after the address is loaded into the register index, and the block acknowledges it.
- R6: In a write, each later byte is acknowledged and produces a one-cycle `regWrEn` pulse carrying the current index on `regIdx` and the byte on `regWdata`. The index then increments, wrapping modulo 2^IDX_W (0xFF is followed by 0x00).
- R7: In a read, the block pulses `regRdEn` with the current index on `regIdx` and captures `regRdata` in that same cycle. It shifts the byte out MSB first and then increments the index, with the same wraparound.
- R8: After each read byte, a master ACK (SDA low on the ninth clock) makes the block fetch and send the next byte. A master NACK releases SDA, and the block stays silent until the next START.
- R9: `sdaOe` changes only while the synchronised SCL is low, except when a START or STOP has just been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock, at least 10x SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as received |
| sdaIn | input | 1 | Bus data line as received (wired level) |
| addrSel | input | 1 | Strap pin selecting the low address bit |
| sdaOe | output | 1 | 1 pulls the data line low |
| regWrEn | output | 1 | One-cycle register write strobe |
| regRdEn | output | 1 | One-cycle register fetch strobe |
| regIdx | output | IDX_W | Current register index |
| regWdata | output | 8 | Write data byte |
| regRdata | input | 8 | Read data for `regIdx`, valid combinationally |

## Verification
On every cycle, the embedded assertions check the following: the data-line enable toggles only in the bus-clock low phase, a STOP always lands in idle, a START clears the bit count, and an address acknowledge is reached only after a match. They also check that every write or fetch strobe lasts one cycle and advances the index by exactly one. The bench's bus scenarios are the only way to show the protocol-level behaviour. That covers the following: the strap pin selecting between the two address bytes, silence after a wrong address, index loading and wraparound over 0xFF, and read data arriving MSB first in the right order. It also covers a master NACK ending a read, and an aborted byte followed by a clean new transfer.

// File: rtl/pinaddr_i2c_pkg.sv
package pinaddr_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR_BYTE,
    ST_ACK_WR,
    ST_RD_BYTE,
    ST_RD_ACK
  } busState_t;

  // Strobes from control to datapath, all valid for a single clk cycle
  typedef struct packed {
    logic clrCnt;    // restart bit counting for a new byte
    logic shiftIn;   // sample SDA into receive shifter, count one bit
    logic loadIdx;   // received byte becomes register index
    logic writeReg;  // write received byte at index, then increment
    logic loadTx;    // fetch byte at index into transmit shifter, increment
    logic shiftTx;   // advance transmit shifter by one bit
  } strobe_t;

endpackage

// File: rtl/pinaddr_i2c_dp.sv
module pinaddr_i2c_dp
  import pinaddr_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 8,
  parameter logic [6:0] BASE_ADDR   = 7'h1C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrSel,
  input  strobe_t          strb,
  input  logic [7:0]       regRdata,
  output logic             sclRise,
  output logic             sclFall,
  output logic             startDet,
  output logic             stopDet,
  output logic             sclSync,
  output logic             sdaSync,
  output logic             byteDone,
  output logic             cntZero,
  output logic             addrMatch,
  output logic             rwBit,
  output logic             txMsb,
  output logic [IDX_W-1:0] idxOut,
  output logic [7:0]       rxByte
);

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclDly;
  logic                   sdaDly;
  logic [CNT_W-1:0]       bitCnt;
  logic [7:0]             rxShift;
  logic [7:0]             txShift;
  logic [IDX_W-1:0]       idxQ;

  // Synchroniser chains, idle-high after reset
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclDly <= 1'b1;
      sdaDly <= 1'b1;
    end else begin
      sclDly <= sclSync;
      sdaDly <= sdaSync;
    end
  end

  assign sclRise  = sclSync & ~sclDly;
  assign sclFall  = ~sclSync & sclDly;
  assign startDet = sclSync & sclDly & sdaDly & ~sdaSync;
  assign stopDet  = sclSync & sclDly & ~sdaDly & sdaSync;

  // Bit counter and receive shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (strb.clrCnt) begin
      bitCnt  <= '0;
    end else if (strb.shiftIn) begin
      bitCnt  <= bitCnt + CNT_W'(1);
      rxShift <= {rxShift[6:0], sdaSync};
    end
  end

  assign byteDone  = (bitCnt == CNT_W'(BYTE_BITS));
  assign cntZero   = (bitCnt == '0);
  assign rxByte    = rxShift;
  assign rwBit     = rxShift[0];
  assign addrMatch = (rxShift[7:1] == {BASE_ADDR[6:1], addrSel});

  // Transmit shifter
  always_ff @(posedge clk) begin
    if (!rstN)              txShift <= 8'hFF;
    else if (strb.loadTx)   txShift <= regRdata;
    else if (strb.shiftTx)  txShift <= {txShift[6:0], 1'b1};
  end

  assign txMsb = txShift[7];

  // Register index with auto-increment
  always_ff @(posedge clk) begin
    if (!rstN)
      idxQ <= '0;
    else if (strb.loadIdx)
      idxQ <= rxShift[IDX_W-1:0];
    else if (strb.writeReg || strb.loadTx)
      idxQ <= idxQ + IDX_W'(1);
  end

  assign idxOut = idxQ;

  // R6
  idx_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeReg |=> idxQ == $past(idxQ) + IDX_W'(1));

  // R7
  idx_after_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |=> idxQ == $past(idxQ) + IDX_W'(1));

  // R2
  start_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> bitCnt == '0);

endmodule

// File: rtl/pinaddr_i2c_ctrl.sv
module pinaddr_i2c_ctrl
  import pinaddr_i2c_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    startDet,
  input  logic    stopDet,
  input  logic    sclSync,
  input  logic    sdaSync,
  input  logic    byteDone,
  input  logic    cntZero,
  input  logic    addrMatch,
  input  logic    rwBit,
  input  logic    txMsb,
  output strobe_t strb,
  output logic    sdaOe
);

  busState_t stateQ, stateD;
  logic      readQ, readD;
  logic      firstQ, firstD;
  logic      ackSeenQ, ackSeenD;

  always_comb begin
    stateD   = stateQ;
    readD    = readQ;
    firstD   = firstQ;
    ackSeenD = ackSeenQ;
    strb     = '0;

    if (stopDet) begin
      stateD = ST_IDLE;
    end else if (startDet) begin
      stateD      = ST_ADDR;
      strb.clrCnt = 1'b1;
    end else begin
      unique case (stateQ)
        ST_IDLE: ;
        ST_ADDR: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            if (addrMatch) begin
              stateD = ST_ACK_ADDR;
              readD  = rwBit;
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (sclFall) begin
            strb.clrCnt = 1'b1;
            if (readQ) begin
              strb.loadTx = 1'b1;
              stateD      = ST_RD_BYTE;
            end else begin
              firstD = 1'b1;
              stateD = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (sclFall && byteDone) begin
            if (firstQ) begin
              strb.loadIdx = 1'b1;
              firstD       = 1'b0;
            end else begin
              strb.writeReg = 1'b1;
            end
            stateD = ST_ACK_WR;
          end
        end
        ST_ACK_WR: begin
          if (sclFall) begin
            strb.clrCnt = 1'b1;
            stateD      = ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (sclRise) strb.shiftIn = 1'b1;
          else if (sclFall) begin
            if (byteDone) begin
              stateD   = ST_RD_ACK;
              ackSeenD = 1'b0;
            end else if (!cntZero) begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            if (sdaSync) stateD = ST_IDLE;
            else         ackSeenD = 1'b1;
          end else if (sclFall && ackSeenQ) begin
            strb.clrCnt = 1'b1;
            strb.loadTx = 1'b1;
            ackSeenD    = 1'b0;
            stateD      = ST_RD_BYTE;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      readQ    <= 1'b0;
      firstQ   <= 1'b0;
      ackSeenQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      readQ    <= readD;
      firstQ   <= firstD;
      ackSeenQ <= ackSeenD;
    end
  end

  assign sdaOe = (stateQ == ST_ACK_ADDR) || (stateQ == ST_ACK_WR) ||
                 ((stateQ == ST_RD_BYTE) && !txMsb);

  // R2
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> stateQ == ST_IDLE);

  // R3
  addr_ack_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ACK_ADDR && $past(stateQ) == ST_ADDR) |-> $past(addrMatch));

  // R9
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> (!$past(sclSync) || $past(startDet) || $past(stopDet)));

  // R6
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeReg |=> !strb.writeReg);

endmodule

// File: rtl/pinaddr_i2c_slave.sv
module pinaddr_i2c_slave
  import pinaddr_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 8,
  parameter logic [6:0] BASE_ADDR   = 7'h1C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrSel,
  output logic             sdaOe,
  output logic             regWrEn,
  output logic             regRdEn,
  output logic [IDX_W-1:0] regIdx,
  output logic [7:0]       regWdata,
  input  logic [7:0]       regRdata
);

  strobe_t strb;
  logic sclRise, sclFall, startDet, stopDet, sclSync, sdaSync;
  logic byteDone, cntZero, addrMatch, rwBit, txMsb;

  pinaddr_i2c_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .IDX_W      (IDX_W),
    .BASE_ADDR  (BASE_ADDR)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .addrSel  (addrSel),
    .strb     (strb),
    .regRdata (regRdata),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sclSync  (sclSync),
    .sdaSync  (sdaSync),
    .byteDone (byteDone),
    .cntZero  (cntZero),
    .addrMatch(addrMatch),
    .rwBit    (rwBit),
    .txMsb    (txMsb),
    .idxOut   (regIdx),
    .rxByte   (regWdata)
  );

  pinaddr_i2c_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sclSync  (sclSync),
    .sdaSync  (sdaSync),
    .byteDone (byteDone),
    .cntZero  (cntZero),
    .addrMatch(addrMatch),
    .rwBit    (rwBit),
    .txMsb    (txMsb),
    .strb     (strb),
    .sdaOe    (sdaOe)
  );

  assign regWrEn = strb.writeReg;
  assign regRdEn = strb.loadTx;

  // R7
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

endmodule

// File: tb/pinaddr_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module pinaddr_i2c_slave_tb_top;

  localparam int QTR = 100;  // quarter SCL period in ns (20 clk cycles)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaOe, regWrEn, regRdEn;
  logic [7:0] regIdx, regWdata, regRdata;
  logic sdaLine;
  logic [7:0] mem [256];

  int checks = 0;
  int fails = 0;
  logic [15:0] expQ[$];

  always #2.5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  pinaddr_i2c_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOe(sdaOe), .regWrEn(regWrEn), .regRdEn(regRdEn), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  // Register storage model outside the block
  assign regRdata = mem[regIdx];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (regWrEn) begin
      mem[regIdx] <= regWdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for register writes
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4/R6 unexpected write", {regIdx, regWdata}, 0);
      end else begin
        automatic logic [15:0] e = expQ.pop_front();
        chk({regIdx, regWdata} == e, "R6 write idx/data", {regIdx, regWdata}, e);
      end
    end
  end

  task automatic busStart();
    sdaM = 1'b1; #(QTR);
    sclM = 1'b1; #(QTR);
    sdaM = 1'b0; #(QTR);
    sclM = 1'b0; #(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; #(QTR);
    sclM = 1'b1; #(QTR);
    sdaM = 1'b1; #(QTR);
  endtask

  task automatic bitXfer(input bit b, output bit r);
    sdaM = b;    #(QTR);
    sclM = 1'b1; #(QTR);
    r = sdaLine; #(QTR);
    sclM = 1'b0; #(QTR);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    bit dummy;
    for (int i = 7; i >= 0; i--) bitXfer(d[i], dummy);
    bitXfer(1'b1, ack);
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b1, r);
      d[i] = r;
    end
    bitXfer(masterAck, r);
  endtask

  // Driver: write a run of bytes from a start index, pushing expectations
  task automatic writeRun(input logic [7:0] addrByte, input logic [7:0] idx,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n);
    bit ack;
    logic [7:0] data [3];
    data[0] = d0; data[1] = d1; data[2] = d2;
    busStart();
    sendByte(addrByte, ack);
    chk(ack == 1'b0, "R3 address ack", ack, 0);
    sendByte(idx, ack);
    chk(ack == 1'b0, "R5 index ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      expQ.push_back({idx + 8'(i), data[i]});
      sendByte(data[i], ack);
      chk(ack == 1'b0, "R6 data ack", ack, 0);
    end
    busStop();
    #(QTR);
    chk(expQ.size() == 0, "R6 all writes seen", expQ.size(), 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    bit ack, r;
    logic [7:0] d;

    // R1: reset state
    repeat (10) @(posedge clk);
    #1;
    chk(sdaOe == 1'b0, "R1 sdaOe in reset", sdaOe, 0);
    chk(regWrEn == 1'b0 && regRdEn == 1'b0, "R1 strobes in reset", {regWrEn, regRdEn}, 0);
    @(negedge clk);
    rstN = 1'b1;
    #(4 * QTR);
    chk(sdaOe == 1'b0, "R1 sdaOe after reset", sdaOe, 0);

    // R3 R5 R6: write with strap low, address byte 0x38
    writeRun(8'h38, 8'h05, 8'h11, 8'h22, 8'h33, 3);

    // R4: wrong address with strap low, nothing acknowledged or written
    busStart();
    sendByte(8'h3A, ack);
    chk(ack == 1'b1, "R4 mismatch nack", ack, 1);
    sendByte(8'h10, ack);
    chk(ack == 1'b1, "R4 silent after mismatch", ack, 1);
    sendByte(8'h99, ack);
    chk(ack == 1'b1, "R4 silent after mismatch 2", ack, 1);
    busStop();
    #(QTR);

    // R3: strap high selects 0x3A, rejects 0x38
    addrSel = 1'b1;
    busStart();
    sendByte(8'h38, ack);
    chk(ack == 1'b1, "R3 old address rejected", ack, 1);
    busStop();
    // R6: auto-increment wraps from 0xFF to 0x00
    writeRun(8'h3A, 8'hFE, 8'hAA, 8'hBB, 8'hCC, 3);

    // R7 R8 R2: set index, repeated START, read three bytes
    busStart();
    sendByte(8'h3A, ack);
    chk(ack == 1'b0, "R3 address ack", ack, 0);
    sendByte(8'h05, ack);
    chk(ack == 1'b0, "R5 index ack", ack, 0);
    busStart();
    sendByte(8'h3B, ack);
    chk(ack == 1'b0, "R2 repeated start read ack", ack, 0);
    recvByte(1'b0, d);
    chk(d == 8'h11, "R7 read byte 0", d, 8'h11);
    recvByte(1'b0, d);
    chk(d == 8'h22, "R7 read byte 1", d, 8'h22);
    recvByte(1'b1, d);
    chk(d == 8'h33, "R7 read byte 2", d, 8'h33);
    #(QTR);
    chk(sdaOe == 1'b0, "R8 released after nack", sdaOe, 0);
    bitXfer(1'b1, r);
    chk(r == 1'b1, "R8 silent after nack", r, 1);
    busStop();

    // R7: read wraps across 0xFF
    busStart();
    sendByte(8'h3A, ack);
    sendByte(8'hFF, ack);
    busStart();
    sendByte(8'h3B, ack);
    recvByte(1'b0, d);
    chk(d == 8'hBB, "R7 read at 0xFF", d, 8'hBB);
    recvByte(1'b1, d);
    chk(d == 8'hCC, "R7 read wrapped to 0x00", d, 8'hCC);
    busStop();

    // R2: STOP in the middle of an address byte, then a clean transfer
    busStart();
    bitXfer(1'b0, r); bitXfer(1'b0, r); bitXfer(1'b1, r); bitXfer(1'b1, r);
    busStop();
    #(QTR);
    chk(sdaOe == 1'b0, "R2 idle after mid-byte stop", sdaOe, 0);
    writeRun(8'h3A, 8'h20, 8'h5C, 8'h00, 8'h00, 1);

    // R4 for reads: mismatched read address gives no fetch data
    busStart();
    sendByte(8'h39, ack);
    chk(ack == 1'b1, "R4 read mismatch nack", ack, 1);
    recvByte(1'b1, d);
    chk(d == 8'hFF, "R4 no data driven", d, 8'hFF);
    busStop();

    #(4 * QTR);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule